// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer with a parameterised number of independent channels (two by default). Each channel holds a 64-bit interval and a 64-bit counter that moves downward on a shared tick strobe. A per-channel prescaler thins those ticks by a power of two. A channel either reloads and keeps going when it expires (periodic) or stops once (one-shot). Channel 0 is meant as the event timer. Channel 1 is meant as a free-running time base: it is loaded with all ones and left periodic, and software inverts its count to get a rising timestamp.

Software reaches the block through a single-cycle synchronous write port and a combinational read port. Two shared registers hold one bit per channel: an interrupt mask and a sticky expiry flag that is cleared by writing 1. The interrupt line is high while any channel has both its flag and its mask bit set. Clearing a channel's enable bit does not stop it at once. The channel runs for a fixed number of further ticks before it halts, so software must wait out that delay before it reprograms the channel.

Top module: `dtim_top`

## Requirements
- R1: After reset every register reads 0, every channel is halted, and `irq_o` is low.
- R2: Register map. Mask at 0x00 and flags at 0x04, bit n for channel n. Channel n's bank starts at 0x10 + 0x20·n and holds control at +0x0, interval low at +0x4, interval high at +0x8, count low at +0xC and count high at +0x10. The count words are read-only, and a write to them has no effect. Control bits: 0 enable, 1 reload, 6:4 prescaler, 7 one-shot (1) or periodic (0). Control bits 3:2 read 0.
- R3: A control write with bit 1 set copies the full 64-bit interval into the counter on the next tick. Bit 1 reads 1 until that tick and 0 after it.
- R4: On each counting step of an enabled channel whose count is not zero, the count drops by one, with a borrow across the 32-bit halves.
- R5: A step taken at count zero is an expiry. In periodic mode the counter then takes the interval value and carries on counting.
- R6: In one-shot mode an expiry leaves the count at zero, clears the enable bit, and stops all further counting.
- R7: With prescaler value p, a running channel takes one counting step every 2^p ticks.
- R8: After a write that clears enable on a running channel, the enable bit reads 0 at once, but the channel keeps counting for 2 more ticks and then halts.
- R9: An expiry sets the channel's flag whether or not its mask bit is set. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: `irq_o` is high exactly when some channel has both its flag and its mask bit set.
- R11: Channels are independent. Activity on one channel leaves the other channels' counts unchanged.
- R12: A channel loaded with an all-ones interval and run periodically with p=0 has an inverted count that equals the number of ticks since the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timer tick strobe, one clock wide per tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
A faulty counter or a lost reload value appears in the count words on the first tick after the fault. Each scenario reads the count back after an exact number of ticks, so an off-by-one in the decrement, the expiry point or the prescaler divide shows up as a wrong count within one interval. A fault in the stop delay or the one-shot logic leaves the count still moving, or stopped too early, and this is visible a few ticks after the disable or the expiry. A fault in flag or mask handling shows on `irq_o` and on the flag register in the same cycle as the write or expiry that should have changed them.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  // shared register addresses
  localparam int A_IEN       = 'h00;
  localparam int A_STS       = 'h04;
  localparam int BANK_BASE   = 'h10;
  localparam int BANK_STRIDE = 'h20;
  // offsets inside a channel bank
  localparam int OFF_CTL     = 'h00;
  localparam int OFF_IVL_LO  = 'h04;
  localparam int OFF_IVL_HI  = 'h08;
  localparam int OFF_CNT_LO  = 'h0C;
  localparam int OFF_CNT_HI  = 'h10;
  // control field positions
  localparam int CTL_EN      = 0;
  localparam int CTL_RLD     = 1;
  localparam int CTL_PRE_LSB = 4;
  localparam int CTL_ONE     = 7;
  localparam int CTL_W       = 8;
endpackage

// File: rtl/dtim_chan.sv
module dtim_chan
  import dtim_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STOP_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                ctl_we,
  input  logic                ivl_lo_we,
  input  logic                ivl_hi_we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [CTL_W-1:0]    ctl_rd,
  output logic [2*DATA_W-1:0] ivl_o,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic                run_o,
  output logic                expire_o
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int STOP_W = $clog2(STOP_TICKS + 1);
  localparam int DIV_W  = 7;

  logic             en_q, en_d, one_q, one_d, rld_q, rld_d, run_q, run_d;
  logic [2:0]       pre_q, pre_d;
  logic [STOP_W-1:0] stop_q, stop_d;
  logic [DIV_W-1:0] div_q, div_d, div_mask;
  logic [7:0]       mask_w;
  logic [CNT_W-1:0] ivl_q, ivl_d, cnt_q, cnt_d;
  logic             step, expire;

  assign mask_w   = (8'd1 << pre_q) - 8'd1;
  assign div_mask = mask_w[DIV_W-1:0];
  assign step     = tick_en && ((div_q & div_mask) == div_mask);

  always_comb begin
    en_d = en_q; one_d = one_q; rld_d = rld_q; run_d = run_q;
    pre_d = pre_q; stop_d = stop_q; div_d = div_q;
    ivl_d = ivl_q; cnt_d = cnt_q; expire = 1'b0;
    if (tick_en && run_q) div_d = div_q + 1'b1;
    if (tick_en) begin
      // pending disable drains one tick at a time
      if (stop_q != '0) begin
        stop_d = stop_q - 1'b1;
        if (stop_q == STOP_W'(1)) run_d = 1'b0;
      end
      if (rld_q) begin
        cnt_d = ivl_q;
        rld_d = 1'b0;
      end else if (run_q && step) begin
        if (cnt_q == '0) begin
          expire = 1'b1;
          if (one_q) begin
            run_d = 1'b0; en_d = 1'b0; stop_d = '0;
          end else begin
            cnt_d = ivl_q;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    if (ivl_lo_we) ivl_d[DATA_W-1:0]     = wdata;
    if (ivl_hi_we) ivl_d[CNT_W-1:DATA_W] = wdata;
    if (ctl_we) begin
      en_d  = wdata[CTL_EN];
      one_d = wdata[CTL_ONE];
      pre_d = wdata[CTL_PRE_LSB +: 3];
      div_d = '0;
      if (wdata[CTL_RLD]) rld_d = 1'b1;
      if (wdata[CTL_EN]) begin
        run_d = 1'b1; stop_d = '0;
      end else if (run_q && stop_q == '0) begin
        stop_d = STOP_W'(STOP_TICKS);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; one_q <= 1'b0; rld_q <= 1'b0; run_q <= 1'b0;
      pre_q <= '0; stop_q <= '0; div_q <= '0; ivl_q <= '0; cnt_q <= '0;
    end else begin
      en_q <= en_d; one_q <= one_d; rld_q <= rld_d; run_q <= run_d;
      pre_q <= pre_d; stop_q <= stop_d; div_q <= div_d; ivl_q <= ivl_d; cnt_q <= cnt_d;
    end
  end

  assign ctl_rd   = {one_q, pre_q, 2'b00, rld_q, en_q};
  assign ivl_o    = ivl_q;
  assign cnt_o    = cnt_q;
  assign run_o    = run_q;
  assign expire_o = expire;
endmodule

// File: rtl/dtim_irq.sv
module dtim_irq #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_we,
  input  logic              sts_we,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] ien_o,
  output logic [NUM_CH-1:0] sts_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ien_q, ien_d, sts_q, sts_d, clr;

  always_comb begin
    clr   = sts_we ? wbits : '0;
    ien_d = ien_we ? wbits : ien_q;
    // a new expiry wins over a clear in the same cycle
    sts_d = (sts_q & ~clr) | expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0; sts_q <= '0;
    end else begin
      ien_q <= ien_d; sts_q <= sts_d;
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/dtim_top.sv
module dtim_top
  import dtim_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int STOP_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic [NUM_CH-1:0] irq_ien, irq_sts, ch_exp, ch_run;
  logic [NUM_CH-1:0] we_ctl, we_lo, we_hi;
  logic [CTL_W-1:0]  ch_ctl [NUM_CH];
  logic [CNT_W-1:0]  ch_ivl [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = BANK_BASE + g * BANK_STRIDE;
    assign we_ctl[g] = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_CTL));
    assign we_lo[g]  = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_IVL_LO));
    assign we_hi[g]  = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_IVL_HI));
    dtim_chan #(.DATA_W(DATA_W), .STOP_TICKS(STOP_TICKS)) u_chan (
      .clk(clk), .rst_n(rst_core_n), .tick_en(tick_en),
      .ctl_we(we_ctl[g]), .ivl_lo_we(we_lo[g]), .ivl_hi_we(we_hi[g]),
      .wdata(bus_wdata), .ctl_rd(ch_ctl[g]), .ivl_o(ch_ivl[g]),
      .cnt_o(ch_cnt[g]), .run_o(ch_run[g]), .expire_o(ch_exp[g])
    );
  end

  dtim_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_core_n),
    .ien_we(bus_wr && bus_addr == ADDR_W'(A_IEN)),
    .sts_we(bus_wr && bus_addr == ADDR_W'(A_STS)),
    .wbits(bus_wdata[NUM_CH-1:0]), .expire(ch_exp),
    .ien_o(irq_ien), .sts_o(irq_sts), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_IEN)) bus_rdata = DATA_W'(irq_ien);
    if (bus_addr == ADDR_W'(A_STS)) bus_rdata = DATA_W'(irq_sts);
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(BANK_BASE + c * BANK_STRIDE + OFF_CTL))
        bus_rdata = DATA_W'(ch_ctl[c]);
      if (bus_addr == ADDR_W'(BANK_BASE + c * BANK_STRIDE + OFF_IVL_LO))
        bus_rdata = ch_ivl[c][DATA_W-1:0];
      if (bus_addr == ADDR_W'(BANK_BASE + c * BANK_STRIDE + OFF_IVL_HI))
        bus_rdata = ch_ivl[c][CNT_W-1:DATA_W];
      if (bus_addr == ADDR_W'(BANK_BASE + c * BANK_STRIDE + OFF_CNT_LO))
        bus_rdata = ch_cnt[c][DATA_W-1:0];
      if (bus_addr == ADDR_W'(BANK_BASE + c * BANK_STRIDE + OFF_CNT_HI))
        bus_rdata = ch_cnt[c][CNT_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/dtim_chk.sv
module dtim_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              clr_bit0,
  input logic              irq_o,
  input logic [NUM_CH-1:0] sts,
  input logic [NUM_CH-1:0] ien,
  input logic              rld0,
  input logic              run0,
  input logic [CNT_W-1:0]  cnt0
);
  AST_RELOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rld0 && tick_en && !(bus_wr && bus_addr == ADDR_W'('h10))) |=> !rld0); // R3

  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt0)); // R7

  AST_HALT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run0) |-> $past(tick_en)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !(bus_wr && bus_addr == ADDR_W'('h04) && clr_bit0)) |=> sts[0]); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq_o); // R10
endmodule

bind dtim_top dtim_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .clr_bit0(bus_wdata[0]), .irq_o(irq_o),
  .sts(irq_sts), .ien(irq_ien), .rld0(ch_ctl[0][1]), .run0(ch_run[0]),
  .cnt0(ch_cnt[0])
);

// File: tb/dtim_top_bench.sv
module dtim_top_bench;
  logic        clk = 1'b0;
  logic        rst_n, tick_en, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dtim_top u_dtim_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd64(input logic [7:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 8'h04, hi);
    d = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a <= 'h40; a += 4) begin
      rd(8'(a), d);
      chk($sformatf("R1 reg %0h", a), 64'(d), 64'd0);
    end
    chk("R1 irq", 64'(irq_o), 64'd0);
  endtask

  task automatic t_reload;
    logic [31:0] d; logic [63:0] c;
    wr(8'h14, 32'h0); wr(8'h18, 32'h1); wr(8'h10, 32'h02);
    rd(8'h10, d); chk("R3 reload pending", 64'(d), 64'h02);
    rd64(8'h1C, c); chk("R3 no load before tick", c, 64'h0);
    ticks(1);
    rd64(8'h1C, c); chk("R3 full load", c, 64'h1_0000_0000);
    rd(8'h10, d); chk("R3 reload self clear", 64'(d), 64'h0);
    wr(8'h1C, 32'h55);
    rd64(8'h1C, c); chk("R2 count read-only", c, 64'h1_0000_0000);
    wr(8'h10, 32'h01); ticks(1);
    rd64(8'h1C, c); chk("R4 borrow", c, 64'h0_FFFF_FFFF);
    wr(8'h10, 32'h0); ticks(3);
  endtask

  task automatic t_periodic;
    logic [31:0] d; logic [63:0] c;
    wr(8'h14, 32'd3); wr(8'h18, 32'h0); wr(8'h10, 32'h03);
    ticks(1); rd64(8'h1C, c); chk("R3 load 3", c, 64'd3);
    ticks(2); rd64(8'h1C, c); chk("R4 decrement", c, 64'd1);
    rd(8'h04, d); chk("R9 no flag before expiry", 64'(d), 64'd0);
    ticks(2); rd64(8'h1C, c); chk("R5 periodic reload", c, 64'd3);
    rd(8'h04, d); chk("R9 flag set unmasked", 64'(d), 64'd1);
    chk("R10 irq masked", 64'(irq_o), 64'd0);
    wr(8'h00, 32'h1); #1 chk("R10 irq on mask", 64'(irq_o), 64'd1);
    wr(8'h04, 32'h0); rd(8'h04, d); chk("R9 write 0 keeps flag", 64'(d), 64'd1);
    wr(8'h04, 32'h1); rd(8'h04, d); chk("R9 write 1 clears", 64'(d), 64'd0);
    #1 chk("R10 irq off after clear", 64'(irq_o), 64'd0);
    wr(8'h10, 32'h0); rd(8'h10, d); chk("R8 enable reads 0", 64'(d), 64'd0);
    ticks(5); rd64(8'h1C, c); chk("R8 two more ticks then halt", c, 64'd1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d; logic [63:0] c;
    wr(8'h34, 32'd2); wr(8'h38, 32'h0); wr(8'h30, 32'h83);
    ticks(1); rd64(8'h3C, c); chk("R3 ch1 load", c, 64'd2);
    ticks(2); rd64(8'h3C, c); chk("R6 at zero", c, 64'd0);
    rd(8'h04, d); chk("R6 no flag yet", 64'(d), 64'd0);
    ticks(1); rd(8'h04, d); chk("R9 ch1 flag bit", 64'(d), 64'd2);
    rd(8'h30, d); chk("R6 enable cleared", 64'(d), 64'h80);
    ticks(3); rd64(8'h3C, c); chk("R6 stays zero", c, 64'd0);
    rd64(8'h1C, c); chk("R11 ch0 untouched", c, 64'd1);
    wr(8'h04, 32'h2);
  endtask

  task automatic t_prescale;
    logic [63:0] c;
    wr(8'h14, 32'd100); wr(8'h18, 32'h0); wr(8'h10, 32'h23);
    ticks(1); rd64(8'h1C, c); chk("R7 load", c, 64'd100);
    ticks(8); rd64(8'h1C, c); chk("R7 div4 eight ticks", c, 64'd98);
    ticks(4); rd64(8'h1C, c); chk("R7 div4 four ticks", c, 64'd97);
    wr(8'h10, 32'h0); ticks(3);
  endtask

  task automatic t_freerun;
    logic [31:0] d; logic [63:0] c;
    wr(8'h34, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF); wr(8'h30, 32'h03);
    ticks(1); rd64(8'h3C, c); chk("R12 start", ~c, 64'd0);
    ticks(5); rd64(8'h3C, c); chk("R12 rises 5", ~c, 64'd5);
    ticks(7); rd64(8'h3C, c); chk("R12 rises 12", ~c, 64'd12);
    rd(8'h04, d); chk("R9 no spurious flag", 64'(d), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reload();
    t_periodic();
    t_oneshot();
    t_prescale();
    t_freerun();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule